// File: doc/BRIEF.md
# Interrupt Request and Enable Controller

This block keeps ten pending-request flags and ten enable flags for a small processor core. Eight of the sources are vectored. The other two are test-only sources that never raise a vector. A rising edge on a source's event line sets its request flag. Software can also set the flag, and a flag set by software behaves exactly like a hardware event. A source whose request and enable flags are both 1 raises its per-source vector request. The block combines all vectored requests into one interrupt request and picks the vector index to present by a fixed priority. Any source with both flags set, including a test source, drives the standby-wake output.

Software reaches the flags in two ways. Single-bit commands set, clear or test-and-clear a request flag, and set or clear an enable flag. A 4-bit nibble port reads and writes four flags of one bank at a time. When the core accepts an interrupt, it returns an acknowledge with the vector index, and the serviced request flag clears on its own. Sources 2 and 3 share vector 2. On acknowledge of that vector, a flag is cleared only when its source is the only one of the pair that is enabled.

Top module: `irq_flag_ctrl`

## Requirements
- R1: While reset is low, and right after it is released, every request and enable flag is 0. `vrq`, `int_req` and `wake` are 0, and every nibble read returns 0.
- R2: A 0-to-1 change on `hw_evt[i]`, sampled at a clock edge, makes request flag i read 1 after the next edge. A line that stays high does not set the flag again once it has been cleared.
- R3: `vrq[i]` is 1 exactly when request flag i and enable flag i are both 1, for sources 0 to 7. `vrq[9:8]` is always 0.
- R4: `wake` is 1 exactly when some source 0 to 9 has both its request flag and its enable flag at 1.
- R5: Sources map to vectors as follows: source 0 to vector 0, source 1 to vector 1, sources 2 and 3 to vector 2, and sources 4 to 7 to vectors 3 to 6. `int_req` is the OR of `vrq`. When it is 1, `int_vec` is the lowest vector number that has a pending source.
- R6: An acknowledge (`ack_valid`=1) with a vector other than 2 clears the request flag of the source mapped to that vector at the next edge.
- R7: An acknowledge of vector 2 clears flag 2 if only enable 2 is set, and clears flag 3 if only enable 3 is set. If both enables are set, it clears neither flag.
- R8: `bit_op` takes these codes: 0 idle, 1 set request, 2 clear request, 3 test-and-clear request, 4 set enable, 5 clear enable. The code acts on source `bit_sel` at the next edge. A `bit_sel` of 10 or more has no effect.
- R9: `bit_rdata` shows request flag `bit_sel` at all times, so it carries the old value during a test-and-clear cycle. The flag reads 0 after that edge.
- R10: The nibble port reads the request bank when `nib_bank`=0 and the enable bank when `nib_bank`=1. Group g covers sources 4g to 4g+3, with bit 0 being the lowest source. In group 2, bits 3:2 read 0 and writes to them are ignored. A write takes effect at the next edge.
- R11: A hardware rising edge on a source wins over a software clear, a test-and-clear, a nibble write of 0 or an acknowledge of that source in the same cycle. The flag ends at 1.
- R12: A request flag set by software with its enable set raises `vrq`, `int_req` and `int_vec` exactly as a hardware event would.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_evt | input | 10 | Source event lines, one per source; a rising edge sets the request flag |
| bit_op | input | 3 | Single-bit command code |
| bit_sel | input | 4 | Source addressed by the single-bit command and by `bit_rdata` |
| bit_rdata | output | 1 | Current request flag of source `bit_sel` |
| nib_we | input | 1 | Nibble write strobe |
| nib_bank | input | 1 | Nibble bank select: 0 request, 1 enable |
| nib_grp | input | 2 | Nibble group select |
| nib_wdata | input | 4 | Nibble write data |
| nib_rdata | output | 4 | Nibble read data |
| ack_valid | input | 1 | Interrupt accepted by the core |
| ack_vec | input | 3 | Vector number being accepted |
| vrq | output | 10 | Per-source qualified vector request |
| int_req | output | 1 | Any vectored request pending |
| int_vec | output | 3 | Vector number of the pending request with the highest priority |
| wake | output | 1 | Standby release request |

## Verification
Every flag drives the outputs combinationally, so a wrong request or enable bit shows up on `vrq`, `wake`, `int_vec` or a nibble read in the cycle right after the edge that stored it. A lost hardware event shows as a missing `vrq` bit, and a missed auto-clear shows as a request that stays up after the acknowledge. On the shared vector, a wrong clear choice leaves the wrong one of the flags 2 and 3 in the request nibble one cycle after the acknowledge. A priority fault shows as a wrong `int_vec` for a pending mask. The bench therefore sweeps every combination of pending vectors.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int N_SRC   = 10;
    localparam int N_VEC   = 7;
    localparam int VEC_W   = $clog2(N_VEC);
    localparam int SEL_W   = $clog2(N_SRC);
    localparam int SEL_SPAN = 1 << SEL_W;
    localparam int NIB_W   = 4;
    localparam int N_GRP   = (N_SRC + NIB_W - 1) / NIB_W;
    localparam int GRP_W   = $clog2(N_GRP);
    localparam int PAD_W   = N_GRP * NIB_W;

    // the pair of sources sharing one vector
    localparam int SH_A    = 2;
    localparam int SH_B    = 3;
    localparam int SH_VEC  = 2;

    typedef enum logic [2:0] {
        OP_IDLE = 3'd0,
        OP_SETR = 3'd1,
        OP_CLRR = 3'd2,
        OP_TCLR = 3'd3,
        OP_EI   = 3'd4,
        OP_DI   = 3'd5
    } bit_op_e;

    typedef struct packed {
        logic [N_SRC-1:0] req;
        logic [N_SRC-1:0] en;
    } flags_t;

    // vector slot of a source, -1 for test-only sources
    function automatic int src_vec(input int s);
        if (s < SH_A)       return s;
        else if (s <= SH_B) return SH_VEC;
        else if (s < 8)     return s - 1;
        else                return -1;
    endfunction

    function automatic logic [N_SRC-1:0] vec_srcs(input int v);
        logic [N_SRC-1:0] m;
        m = '0;
        for (int s = 0; s < N_SRC; s++)
            if (src_vec(s) == v) m[s] = 1'b1;
        return m;
    endfunction

    function automatic logic [N_SRC-1:0] vectored_mask();
        logic [N_SRC-1:0] m;
        m = '0;
        for (int s = 0; s < N_SRC; s++)
            if (src_vec(s) >= 0) m[s] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/irqc_edge.sv
module irqc_edge #(
    parameter int W = irqc_pkg::N_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    output logic [W-1:0] rise
);
    logic [W-1:0] evt_d, evt_q;

    always_comb begin
        evt_d = evt;
        rise  = evt & ~evt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= evt_d;
    end
endmodule

// File: rtl/irqc_flags.sv
module irqc_flags
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] rise,
    input  logic [2:0]       bit_op,
    input  logic [SEL_W-1:0] bit_sel,
    input  logic             nib_we,
    input  logic             nib_bank,
    input  logic [GRP_W-1:0] nib_grp,
    input  logic [NIB_W-1:0] nib_wdata,
    input  logic             ack_valid,
    input  logic [VEC_W-1:0] ack_vec,
    output logic [N_SRC-1:0] req_q,
    output logic [N_SRC-1:0] en_q
);
    flags_t f_d, f_q;
    logic [PAD_W-1:0]    rpad, epad;
    logic [SEL_SPAN-1:0] rsel, esel;
    bit_op_e             op;

    always_comb begin
        op = bit_op_e'(bit_op);
        f_d = f_q;

        // nibble access, padded so the missing bits of the top group drop out
        rpad = PAD_W'(f_q.req);
        epad = PAD_W'(f_q.en);
        if (nib_we) begin
            for (int g = 0; g < N_GRP; g++) begin
                if (nib_grp == GRP_W'(g)) begin
                    if (nib_bank) epad[g*NIB_W +: NIB_W] = nib_wdata;
                    else          rpad[g*NIB_W +: NIB_W] = nib_wdata;
                end
            end
        end

        // single-bit commands, padded so out-of-range selects do nothing
        rsel = SEL_SPAN'(rpad[N_SRC-1:0]);
        esel = SEL_SPAN'(epad[N_SRC-1:0]);
        unique case (op)
            OP_SETR: rsel[bit_sel] = 1'b1;
            OP_CLRR,
            OP_TCLR: rsel[bit_sel] = 1'b0;
            OP_EI:   esel[bit_sel] = 1'b1;
            OP_DI:   esel[bit_sel] = 1'b0;
            default: ;
        endcase
        f_d.req = rsel[N_SRC-1:0];
        f_d.en  = esel[N_SRC-1:0];

        // auto-clear on acknowledge
        if (ack_valid) begin
            if (int'(ack_vec) == SH_VEC) begin
                if (f_q.en[SH_A] && !f_q.en[SH_B]) f_d.req[SH_A] = 1'b0;
                if (f_q.en[SH_B] && !f_q.en[SH_A]) f_d.req[SH_B] = 1'b0;
            end else begin
                for (int s = 0; s < N_SRC; s++)
                    if (src_vec(s) == int'(ack_vec)) f_d.req[s] = 1'b0;
            end
        end

        // hardware events are applied last so they are never lost
        f_d.req = f_d.req | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign req_q = f_q.req;
    assign en_q  = f_q.en;
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
    import irqc_pkg::*;
(
    input  logic [N_SRC-1:0] vrq,
    output logic             int_req,
    output logic [VEC_W-1:0] int_vec
);
    logic [N_VEC-1:0] pend;

    for (genvar v = 0; v < N_VEC; v++) begin : g_pend
        assign pend[v] = |(vrq & vec_srcs(v));
    end

    always_comb begin
        int_req = |pend;
        int_vec = '0;
        for (int v = N_VEC - 1; v >= 0; v--)
            if (pend[v]) int_vec = VEC_W'(v);
    end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] hw_evt,
    input  logic [2:0]       bit_op,
    input  logic [SEL_W-1:0] bit_sel,
    output logic             bit_rdata,
    input  logic             nib_we,
    input  logic             nib_bank,
    input  logic [GRP_W-1:0] nib_grp,
    input  logic [NIB_W-1:0] nib_wdata,
    output logic [NIB_W-1:0] nib_rdata,
    input  logic             ack_valid,
    input  logic [VEC_W-1:0] ack_vec,
    output logic [N_SRC-1:0] vrq,
    output logic             int_req,
    output logic [VEC_W-1:0] int_vec,
    output logic             wake
);
    localparam logic [N_SRC-1:0] VEC_MASK = vectored_mask();

    logic [N_SRC-1:0]    evt_rise;
    logic [N_SRC-1:0]    req_q, en_q;
    logic [SEL_SPAN-1:0] req_wide;
    logic [PAD_W-1:0]    rd_pad;

    irqc_edge #(.W(N_SRC)) i_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .evt  (hw_evt),
        .rise (evt_rise)
    );

    irqc_flags i_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (evt_rise),
        .bit_op   (bit_op),
        .bit_sel  (bit_sel),
        .nib_we   (nib_we),
        .nib_bank (nib_bank),
        .nib_grp  (nib_grp),
        .nib_wdata(nib_wdata),
        .ack_valid(ack_valid),
        .ack_vec  (ack_vec),
        .req_q    (req_q),
        .en_q     (en_q)
    );

    assign vrq  = req_q & en_q & VEC_MASK;
    assign wake = |(req_q & en_q);

    irqc_arb i_arb (
        .vrq    (vrq),
        .int_req(int_req),
        .int_vec(int_vec)
    );

    always_comb begin
        req_wide  = SEL_SPAN'(req_q);
        bit_rdata = req_wide[bit_sel];
        rd_pad    = nib_bank ? PAD_W'(en_q) : PAD_W'(req_q);
        nib_rdata = '0;
        for (int g = 0; g < N_GRP; g++)
            if (nib_grp == GRP_W'(g)) nib_rdata = rd_pad[g*NIB_W +: NIB_W];
    end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] rise,
    input logic [N_SRC-1:0] req,
    input logic [N_SRC-1:0] vrq,
    input logic             int_req,
    input logic [VEC_W-1:0] int_vec,
    input logic             wake
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (vrq == '0 && !int_req && !wake));

    // R2 R11
    edge_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((req & $past(rise)) == $past(rise)));

    // R4
    req_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> wake);

    // R5
    combined_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_req == (|vrq));

    // R5
    top_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vrq[0] |-> (int_vec == '0));
endmodule

bind irq_flag_ctrl irqc_chk i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise   (evt_rise),
    .req    (req_q),
    .vrq    (vrq),
    .int_req(int_req),
    .int_vec(int_vec),
    .wake   (wake)
);

// File: tb/test_irq_flag_ctrl.sv
`timescale 1ns/1ps
module test_irq_flag_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] hw_evt = '0;
    logic [2:0] bit_op = '0;
    logic [3:0] bit_sel = '0;
    logic       bit_rdata;
    logic       nib_we = 1'b0;
    logic       nib_bank = 1'b0;
    logic [1:0] nib_grp = '0;
    logic [3:0] nib_wdata = '0;
    logic [3:0] nib_rdata;
    logic       ack_valid = 1'b0;
    logic [2:0] ack_vec = '0;
    logic [9:0] vrq;
    logic       int_req;
    logic [2:0] int_vec;
    logic       wake;

    always #2.5 clk = ~clk;

    irq_flag_ctrl i_irq_flag_ctrl (
        .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt),
        .bit_op(bit_op), .bit_sel(bit_sel), .bit_rdata(bit_rdata),
        .nib_we(nib_we), .nib_bank(nib_bank), .nib_grp(nib_grp),
        .nib_wdata(nib_wdata), .nib_rdata(nib_rdata),
        .ack_valid(ack_valid), .ack_vec(ack_vec),
        .vrq(vrq), .int_req(int_req), .int_vec(int_vec), .wake(wake)
    );

    int checks = 0;
    int errors = 0;
    logic [9:0] m_req = '0;
    logic [9:0] m_en  = '0;

    task automatic chk(input string r, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
        end
    endtask

    function automatic int sv(input int s);
        if (s < 2) return s;
        if (s < 4) return 2;
        if (s < 8) return s - 1;
        return -1;
    endfunction

    function automatic int exp_vec();
        for (int v = 0; v < 7; v++)
            for (int s = 0; s < 10; s++)
                if (sv(s) == v && m_req[s] && m_en[s]) return v;
        return -1;
    endfunction

    task automatic check_outs(input string r);
        int ev;
        ev = exp_vec();
        chk(r, "vrq", 32'(vrq), 32'(m_req & m_en & 10'h0FF));
        chk(r, "wake", 32'(wake), 32'(|(m_req & m_en)));
        chk(r, "int_req", 32'(int_req), 32'(ev >= 0));
        if (ev >= 0) chk(r, "int_vec", 32'(int_vec), 32'(ev));
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        bit_op = 3'd0;
        nib_we = 1'b0;
        ack_valid = 1'b0;
    endtask

    task automatic bitop(input logic [2:0] op, input int s);
        bit_op = op;
        bit_sel = 4'(s);
        cyc();
    endtask

    task automatic nibw(input logic bank, input int g, input logic [3:0] d);
        nib_we = 1'b1; nib_bank = bank; nib_grp = 2'(g); nib_wdata = d;
        cyc();
    endtask

    task automatic nibr(input string r, input logic bank, input int g,
                        input logic [3:0] exp);
        nib_bank = bank; nib_grp = 2'(g);
        #1;
        chk(r, "nib_rdata", 32'(nib_rdata), 32'(exp));
    endtask

    task automatic ack(input int v);
        ack_valid = 1'b1; ack_vec = 3'(v);
        cyc();
    endtask

    task automatic write_req(input logic [9:0] r);
        nibw(1'b0, 0, r[3:0]);
        nibw(1'b0, 1, r[7:4]);
        nibw(1'b0, 2, {2'b00, r[9:8]});
        m_req = r;
    endtask

    task automatic write_en(input logic [9:0] e);
        nibw(1'b1, 0, e[3:0]);
        nibw(1'b1, 1, e[7:4]);
        nibw(1'b1, 2, {2'b00, e[9:8]});
        m_en = e;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        @(negedge clk); @(negedge clk);
        check_outs("R1");
        for (int g = 0; g < 3; g++) begin
            nibr("R1", 1'b0, g, 4'h0);
            nibr("R1", 1'b1, g, 4'h0);
        end
        rst_n = 1'b1;
        cyc();
        check_outs("R1");

        // per-source sweep
        for (int s = 0; s < 10; s++) begin
            hw_evt[s] = 1'b1;
            cyc();
            m_req[s] = 1'b1;
            bit_sel = 4'(s); #1;
            chk("R2", "set by edge", 32'(bit_rdata), 1);
            check_outs("R3");
            bitop(3'd2, s);                 // clear while line still high
            m_req[s] = 1'b0;
            #1 chk("R2", "no re-set while held", 32'(bit_rdata), 0);
            hw_evt[s] = 1'b0;
            cyc();
            hw_evt[s] = 1'b1;
            cyc();
            hw_evt[s] = 1'b0;
            m_req[s] = 1'b1;
            bitop(3'd4, s);
            m_en[s] = 1'b1;
            check_outs("R3");
            check_outs("R4");
            if (sv(s) >= 0) begin
                ack(sv(s));
                m_req[s] = 1'b0;
                #1 chk("R6", "cleared by ack", 32'(bit_rdata), 0);
            end else begin
                chk("R4", "test source no int", 32'(int_req), 0);
                bitop(3'd2, s);
                m_req[s] = 1'b0;
            end
            check_outs("R6");
            bitop(3'd5, s);
            m_en[s] = 1'b0;
            check_outs("R8");
        end

        // R5 priority sweep over every pending vector set
        write_en(10'h3FF);
        for (int mask = 0; mask < 128; mask++) begin
            logic [9:0] r;
            r = '0;
            r[0] = mask[0];
            r[1] = mask[1];
            if (mask[0]) r[3] = mask[2]; else r[2] = mask[2];
            r[7:4] = 4'(mask >> 3);
            r[8] = mask[1];
            r[9] = mask[5];
            write_req(r);
            check_outs("R5");
            nibr("R10", 1'b0, 1, r[7:4]);
        end
        write_req('0);

        // R7 shared vector clear rules
        write_en(10'h004);
        write_req(10'h00C);
        ack(2);
        nibr("R7", 1'b0, 0, 4'b1000);
        write_en(10'h008);
        write_req(10'h00C);
        ack(2);
        nibr("R7", 1'b0, 0, 4'b0100);
        write_en(10'h00C);
        write_req(10'h00C);
        ack(2);
        nibr("R7", 1'b0, 0, 4'b1100);
        check_outs("R7");
        write_req('0);
        write_en('0);

        // R12 software set, R9 test-and-clear
        bitop(3'd4, 5); m_en[5] = 1'b1;
        bitop(3'd1, 5); m_req[5] = 1'b1;
        check_outs("R12");
        chk("R12", "int_vec", 32'(int_vec), 4);
        bit_op = 3'd3; bit_sel = 4'd5;
        #1 chk("R9", "old value", 32'(bit_rdata), 1);
        cyc();
        m_req[5] = 1'b0;
        #1 chk("R9", "cleared", 32'(bit_rdata), 0);
        check_outs("R9");
        bit_op = 3'd3; bit_sel = 4'd5;
        #1 chk("R9", "zero flag", 32'(bit_rdata), 0);
        cyc();
        #1 chk("R9", "stays zero", 32'(bit_rdata), 0);

        // R8 out-of-range select has no effect
        bitop(3'd1, 12);
        bitop(3'd4, 15);
        nibr("R8", 1'b0, 2, 4'h0);
        nibr("R8", 1'b1, 2, 4'h0);
        check_outs("R8");

        // R4 test source wakes but raises no interrupt
        bitop(3'd4, 9); m_en[9] = 1'b1;
        bitop(3'd1, 9); m_req[9] = 1'b1;
        chk("R4", "wake", 32'(wake), 1);
        chk("R4", "int_req", 32'(int_req), 0);
        check_outs("R4");

        // R10 unused bits of the top group
        write_req('0);
        write_en('0);
        nibw(1'b0, 2, 4'hF);
        m_req[9:8] = 2'b11;
        nibr("R10", 1'b0, 2, 4'h3);
        nibw(1'b1, 2, 4'hF);
        m_en[9:8] = 2'b11;
        nibr("R10", 1'b1, 2, 4'h3);
        check_outs("R10");
        write_req('0);
        write_en('0);

        // R11 hardware set beats software clear, test-and-clear, ack, nibble 0
        hw_evt[6] = 1'b1; bit_op = 3'd2; bit_sel = 4'd6;
        cyc();
        m_req[6] = 1'b1;
        #1 chk("R11", "vs clear", 32'(bit_rdata), 1);
        hw_evt[6] = 1'b0;
        cyc();
        bitop(3'd4, 6); m_en[6] = 1'b1;
        hw_evt[6] = 1'b1; ack_valid = 1'b1; ack_vec = 3'd5;
        cyc();
        hw_evt[6] = 1'b0;
        #1 chk("R11", "vs ack", 32'(bit_rdata), 1);
        check_outs("R11");
        cyc();
        hw_evt[6] = 1'b1; bit_op = 3'd3; bit_sel = 4'd6;
        cyc();
        hw_evt[6] = 1'b0;
        #1 chk("R11", "vs test-clear", 32'(bit_rdata), 1);
        cyc();
        hw_evt[6] = 1'b1; nib_we = 1'b1; nib_bank = 1'b0; nib_grp = 2'd1; nib_wdata = 4'h0;
        cyc();
        hw_evt[6] = 1'b0;
        nibr("R11", 1'b0, 1, 4'b0100);

        // R1 reset in mid-run
        write_en(10'h3FF);
        write_req(10'h3FF);
        rst_n = 1'b0;
        m_req = '0; m_en = '0;
        cyc();
        check_outs("R1");
        nibr("R1", 1'b0, 0, 4'h0);
        nibr("R1", 1'b1, 1, 4'h0);
        rst_n = 1'b1;
        cyc();
        check_outs("R1");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule